// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits load current in an H-bridge one cycle of chopping at a time. It sits between the input decoder, which produces the requested bridge state, and the gate drive. A digital flag from an external current comparator says that the sensed current has reached the trip level. When the flag is accepted, the block overrides the requested state and puts the bridge into slow decay, with both low-side switches on, for a fixed number of clock cycles. After that it returns control to the requested state.

The comparator flag is unreliable for a short time after drive is applied, because of switching transients. For that reason every new drive interval opens with a blanking window in which the flag is ignored. A new drive interval starts on entry into forward or reverse, on a change of direction, and at the end of every off time. The flag matters only while forward or reverse is requested. Coast and brake ignore it and end any off time in progress. A direction change requested during an off time is held until the off time is over, and then takes effect with a fresh blanking window. PWM on the inputs works the same way as static inputs.

Top module: `fixed_off_chopper`

## Requirements
- R1: During and directly after reset, `ovr_en` and `chop_active` are 0 and `bridge_cmd` equals `req_state`.
- R2: State encoding is 2'b00 coast, 2'b01 reverse, 2'b10 forward, 2'b11 brake (both low-side on). While `ovr_en` is 0, `bridge_cmd` equals `req_state` in the same cycle.
- R3: `trip_in` passes through `SYNC_STAGES` flip-flops. When a drive interval is past its blanking window and the synchronized flag is 1 at a clock edge, `ovr_en` becomes 1 after that edge (for the default of 2 stages, three edges after `trip_in` rises).
- R4: While `ovr_en` is 1, `bridge_cmd` is 2'b11. With forward or reverse held, `ovr_en` stays 1 for exactly `OFF_CYC` cycles.
- R5: After a drive interval starts, the flag is ignored for `BLANK_CYC` cycles. A trip can be accepted no earlier than `BLANK_CYC`+1 cycles after the start, so a flag pulse confined to the window has no effect.
- R6: While the requested state is coast or brake, the flag is ignored. A request for coast or brake during an off time clears `ovr_en` at the next edge.
- R7: A change between forward and reverse during an off time does not shorten it. When the off time ends, `bridge_cmd` follows the new direction and a fresh blanking window begins.
- R8: `chop_active` rises together with `ovr_en`. It stays 1 through later blanking windows of the same drive interval. It clears when coast or brake is requested, or when the direction changes outside an off time.
- R9: Chopping works in forward and in reverse. With the flag held, it repeats off time and blanking, whether the inputs are static or switch between drive and brake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_state | input | 2 | Bridge state requested by the decoder |
| trip_in | input | 1 | Asynchronous over-trip comparator flag |
| bridge_cmd | output | 2 | Bridge state to the gate drive |
| ovr_en | output | 1 | Override request, high during an off time |
| chop_active | output | 1 | Chopping status for the current drive interval |

## Verification
The reference model runs with the flag held low in each of the four states. This separates plain pass-through from any override. With the flag held high under static forward and static reverse, it shows the repeating off time and blanking rhythm and the exact off length. A flag pulse confined to the blanking window distinguishes correct blanking from a window that is too short. Brake and coast with the flag high, a drop to coast in the middle of an off time, a direction change during an off time, and a drive/brake PWM pattern each separate abandoning, holding and restarting an interval from the wrong alternatives.

// File: rtl/fixed_off_chopper.sv
module fixed_off_chopper #(
  parameter int SYNC_STAGES = 2,
  parameter int BLANK_CYC   = 100,
  parameter int OFF_CYC     = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_state,
  input  logic       trip_in,
  output logic [1:0] bridge_cmd,
  output logic       ovr_en,
  output logic       chop_active
);
  localparam int LIM = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [1:0] ST_BRAKE = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_BLANK, S_ARMED, S_OFF} phase_t;

  phase_t                 phase;
  logic [CW-1:0]          cnt;
  logic [1:0]             req_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   trip_s, drive, dir_chg;

  assign trip_s  = sync_q[SYNC_STAGES-1];
  assign drive   = req_state[1] ^ req_state[0];
  assign dir_chg = req_state != req_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], trip_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= S_IDLE;
      cnt         <= '0;
      req_q       <= 2'b00;
      chop_active <= 1'b0;
    end else begin
      req_q <= req_state;
      if (!drive) begin
        phase       <= S_IDLE;
        cnt         <= '0;
        chop_active <= 1'b0;
      end else begin
        case (phase)
          S_IDLE: begin
            phase <= S_BLANK;
            cnt   <= '0;
          end
          S_BLANK:
            if (dir_chg) begin
              cnt         <= '0;
              chop_active <= 1'b0;
            end else if (cnt == CW'(BLANK_CYC - 1)) begin
              phase <= S_ARMED;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_ARMED:
            if (dir_chg) begin
              phase       <= S_BLANK;
              cnt         <= '0;
              chop_active <= 1'b0;
            end else if (trip_s) begin
              phase       <= S_OFF;
              cnt         <= '0;
              chop_active <= 1'b1;
            end
          default:
            if (cnt == CW'(OFF_CYC - 1)) begin
              phase <= S_BLANK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
        endcase
      end
    end
  end

  assign ovr_en     = phase == S_OFF;
  assign bridge_cmd = ovr_en ? ST_BRAKE : req_state;
endmodule

// File: rtl/fixed_off_chopper_chk.sv
module fixed_off_chopper_chk #(
  parameter int BLANK_CYC = 100,
  parameter int OFF_CYC   = 1250
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_state,
  input logic       trip_s,
  input logic       ovr_en,
  input logic       chop_active
);
  int off_run;
  int gap;
  logic drive;
  assign drive = req_state[1] ^ req_state[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      off_run <= 0;
      gap     <= 0;
    end else begin
      off_run <= ovr_en ? off_run + 1 : 0;
      if (ovr_en)            gap <= 0;
      else if (gap < 1 << 30) gap <= gap + 1;
    end

  assert_trip_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_en) |-> $past(trip_s));
  assert_off_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |-> off_run < OFF_CYC);
  assert_blank_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_en) |-> gap >= BLANK_CYC);
  assert_idle_no_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |=> !ovr_en);
  assert_start_in_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_en) |-> $past(drive));
  assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |-> chop_active);
endmodule

bind fixed_off_chopper fixed_off_chopper_chk #(.BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_state(req_state), .trip_s(trip_s),
  .ovr_en(ovr_en), .chop_active(chop_active));

// File: tb/test_fixed_off_chopper.sv
module test_fixed_off_chopper;
  localparam int BLANK = 4;
  localparam int OFFC  = 8;

  logic clk = 1'b0, rst_n = 1'b0, trip_in = 1'b0;
  logic [1:0] req_state = 2'b00;
  logic [1:0] bridge_cmd;
  logic ovr_en, chop_active;

  int errors = 0, checks = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  fixed_off_chopper #(.SYNC_STAGES(2), .BLANK_CYC(BLANK), .OFF_CYC(OFFC)) i_fixed_off_chopper (
    .clk(clk), .rst_n(rst_n), .req_state(req_state), .trip_in(trip_in),
    .bridge_cmd(bridge_cmd), .ovr_en(ovr_en), .chop_active(chop_active));

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit q[$] = '{1'b0, 1'b0};
  int ph = 0, cnt = 0, prevreq = 0;
  bit m_chop = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = '{1'b0, 1'b0}; ph = 0; cnt = 0; prevreq = 0; m_chop = 0;
    end else begin
      bit ts, drv, chg;
      ts = q[0];
      void'(q.pop_front());
      q.push_back(trip_in);
      drv = (req_state == 2'b01) || (req_state == 2'b10);
      chg = int'(req_state) != prevreq;
      if (!drv) begin ph = 0; cnt = 0; m_chop = 0; end
      else if (ph == 0) begin ph = 1; cnt = 0; end
      else if (ph == 1) begin
        if (chg) begin cnt = 0; m_chop = 0; end
        else if (cnt == BLANK - 1) ph = 2;
        else cnt++;
      end else if (ph == 2) begin
        if (chg) begin ph = 1; cnt = 0; m_chop = 0; end
        else if (ts) begin ph = 3; cnt = 0; m_chop = 1; end
      end else begin
        if (cnt == OFFC - 1) begin ph = 1; cnt = 0; end
        else cnt++;
      end
      prevreq = int'(req_state);
    end
  end

  int cur_run = 0, last_run = 0, ovr_seen = 0;
  always @(negedge clk) begin
    int exp_cmd;
    bit exp_ovr;
    exp_ovr = (ph == 3);
    exp_cmd = exp_ovr ? 3 : int'(req_state);
    chk(ovr_en == exp_ovr, {tag, " ovr_en"}, ovr_en, exp_ovr);
    chk(int'(bridge_cmd) == exp_cmd, {tag, " bridge_cmd"}, bridge_cmd, exp_cmd);
    chk(chop_active == m_chop, {tag, " chop_active"}, chop_active, m_chop);
    if (ovr_en) begin cur_run++; ovr_seen++; end
    else if (cur_run != 0) begin last_run = cur_run; cur_run = 0; end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_ovr();
    while (!ovr_en) cyc(1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #40000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk(!ovr_en && !chop_active && bridge_cmd == req_state, "R1 reset", ovr_en, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(!ovr_en && !chop_active, "R1 after reset", chop_active, 0);

    tag = "R2";
    req_state = 2'b10; cyc(10);
    req_state = 2'b01; cyc(10);
    req_state = 2'b11; cyc(5);
    req_state = 2'b00; cyc(5);
    chk(ovr_seen == 0, "R2 no override without flag", ovr_seen, 0);

    tag = "R5";
    req_state = 2'b10; trip_in = 1'b1; cyc(2);
    trip_in = 1'b0; cyc(12);
    chk(ovr_seen == 0, "R5 pulse in blanking ignored", ovr_seen, 0);

    tag = "R3";
    trip_in = 1'b1; cyc(3);
    chk(ovr_en == 1'b1, "R3 trip latency", ovr_en, 1);
    tag = "R4";
    cyc(OFFC + 1);
    chk(last_run == OFFC, "R4 off length", last_run, OFFC);
    tag = "R9";
    cyc(30);
    chk(chop_active == 1'b1, "R9 forward repeated chop", chop_active, 1);

    req_state = 2'b00; trip_in = 1'b0; cyc(3);
    req_state = 2'b01; trip_in = 1'b1; ovr_seen = 0; cyc(30);
    chk(ovr_seen > 0, "R9 reverse chop", ovr_seen, 1);

    tag = "R6";
    req_state = 2'b11; ovr_seen = 0; cyc(10);
    req_state = 2'b00; cyc(10);
    chk(ovr_seen == 0, "R6 flag ignored in brake/coast", ovr_seen, 0);
    req_state = 2'b10; wait_ovr(); cyc(2);
    req_state = 2'b00; cyc(1);
    chk(ovr_en == 1'b0 && chop_active == 1'b0, "R6 off time abandoned", ovr_en, 0);
    cyc(3);

    tag = "R7";
    req_state = 2'b10; wait_ovr(); cyc(1);
    req_state = 2'b01; trip_in = 1'b0; cyc(1);
    chk(bridge_cmd == 2'b11, "R7 held during off", bridge_cmd, 3);
    cyc(OFFC);
    chk(last_run == OFFC && bridge_cmd == 2'b01, "R7 new direction after off", bridge_cmd, 1);
    tag = "R8";
    chk(chop_active == 1'b1, "R8 status kept in blanking", chop_active, 1);
    cyc(10);
    req_state = 2'b10; cyc(1);
    chk(chop_active == 1'b0, "R8 cleared by direction change", chop_active, 0);

    tag = "R9";
    trip_in = 1'b1; ovr_seen = 0;
    for (int i = 0; i < 6; i++) begin
      req_state = 2'b10; cyc(12);
      req_state = 2'b11; cyc(4);
    end
    chk(ovr_seen > 0, "R9 PWM chop", ovr_seen, 1);
    req_state = 2'b00; trip_in = 1'b0; cyc(4);
    finish_run();
  end
endmodule